// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with LRU Replacement

This block is a small read cache that sits between a requester and a slow word memory. A 7-bit byte address is split into a tag, a set index and a byte offset. Both ways of the addressed set compare their tags against the request in the same cycle. The hitting way's word is returned through a two-input select. A miss issues a single-word fetch on a simple refill port, installs the returned word and forwards it to the requester.

Each set keeps one replacement bit that names the way to evict next. A fill always takes an empty way before it displaces valid data. A hit or a fill makes the other way the next victim. The associativity is a parameter. With one way and eight sets, the same storage becomes a direct-mapped cache, which is useful when comparing hit patterns on one address trace. Two counters report how many lookups hit and how many missed.

Top module: `assoc_lru_cache`

## Requirements
- R1: After reset req_ready is 1, rsp_valid and mem_req_valid are 0, both counters are 0, and every way is invalid, so the first access to any address misses.
- R2: The byte address is split as tag = bits [6:4], set = bits [3:2], offset = bits [1:0]. The offset is ignored, so addresses that differ only in bits [1:0] hit the same stored word.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. If a valid way of the set holds the tag, then on the next edge rsp_valid=1, rsp_hit=1 and rsp_data is the stored word, and no memory request is made.
- R4: On a miss, mem_req_valid rises on the edge after acceptance, with mem_req_addr = byte address bits [6:2]. It stays high with a stable address until an edge where mem_rsp_valid=1. On that edge rsp_valid=1, rsp_hit=0 and rsp_data=mem_rsp_data, and the word is installed.
- R5: A fill goes to an invalid way of the set if one exists, with way 0 taken before way 1. Only when both ways are valid is the way named by the set's replacement bit overwritten.
- R6: After a hit in way w, or a fill of way w, the set's replacement bit names the other way. Other sets are unchanged.
- R7: From reset, with two ways and four sets, the word-address trace 0, 8, 0, 6, 8, 16 (byte addresses 0, 32, 0, 24, 32, 64) gives miss, miss, hit, miss, hit, miss.
- R8: With one way and eight sets (set = bits [4:2], tag = bits [6:5]), the same trace misses on all six accesses.
- R9: hit_count increases by one on the edge of each hit response. miss_count increases by one on the edge where a miss raises mem_req_valid. Neither counter changes otherwise.
- R10: req_ready is 1 only while the cache is idle. A req_valid presented while req_ready is 0 is ignored: it produces no response and no counter change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W (7) | Byte address of the lookup |
| req_ready | output | 1 | Cache idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 when the response came from a hit |
| rsp_data | output | DATA_W (32) | Returned word |
| mem_req_valid | output | 1 | Refill fetch request, held until answered |
| mem_req_addr | output | ADDR_W-OFF_W (5) | Word address of the fetch |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | DATA_W (32) | Refill word |
| hit_count | output | CNT_W (16) | Number of hits since reset |
| miss_count | output | CNT_W (16) | Number of misses since reset |

## Verification
The hardest state to reach is a full set whose replacement bit points at the way that was touched longest ago. Getting there needs a third distinct tag in that set after a hit has reordered the two residents. The stimulus builds this on purpose with a hand-written pattern in one set, plus the six-access trace, before a long pseudo-random sweep. The sweep uses full byte addresses, so offsets, conflicts and refills interleave. A reference model in the bench predicts every hit or miss and every returned word. Requests injected while a refill is pending probe the ignored-input rule through the counters.

// File: rtl/alc_pkg.sv
`timescale 1ns/1ps
package alc_pkg;

   // Controller phases of the lookup engine.
   typedef enum logic [1:0] {
      CS_IDLE   = 2'd0,
      CS_LOOKUP = 2'd1,
      CS_REFILL = 2'd2
   } ctl_state_e;

   // Width of a way index; one bit is kept even for a single way.
   function automatic int unsigned way_idx_w(input int unsigned ways);
      return (ways > 1) ? $clog2(ways) : 1;
   endfunction

endpackage

// File: rtl/alc_way_store.sv
`timescale 1ns/1ps
// Storage of one way: valid bits, tags and data words, one entry per set.
module alc_way_store #(
   parameter int unsigned SET_W  = 2,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [SET_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int unsigned SETS = 1 << SET_W;

   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   // Only the valid bits need a reset; tag and data are qualified by them.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];

   // R4: a fill leaves the entry valid and holding the written tag.
   a_r4_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))));

endmodule

// File: rtl/alc_tag_match.sv
`timescale 1ns/1ps
// Parallel tag compare over all ways of the indexed set and AND-OR data select.
module alc_tag_match #(
   parameter int unsigned WAYS   = 2,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WAY_W  = 1
) (
   input  logic [WAYS-1:0]             way_valid,
   input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic [WAYS-1:0][DATA_W-1:0] way_data,
   input  logic [TAG_W-1:0]            look_tag,
   output logic [WAYS-1:0]             hit_vec,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way,
   output logic [DATA_W-1:0]           hit_data
);
   genvar g;
   for (g = 0; g < WAYS; g++) begin : g_cmp
      assign hit_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
   end

   assign hit = |hit_vec;

   // At most one way matches, so OR-combining the qualified words is a mux.
   always_comb begin
      hit_data = '0;
      hit_way  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit_data = hit_data | way_data[w];
            hit_way  = hit_way | WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/alc_replace.sv
`timescale 1ns/1ps
// Victim choice per set: empty ways first, otherwise the least recently used way.
module alc_replace #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned SET_W = 2,
   parameter int unsigned WAY_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  idx,
   input  logic [WAYS-1:0]   set_valid,
   input  logic              touch_en,
   input  logic [SET_W-1:0]  touch_idx,
   input  logic [WAY_W-1:0]  touch_way,
   output logic [WAY_W-1:0]  victim_way
);
   localparam int unsigned SETS = 1 << SET_W;

   if (WAYS == 1) begin : g_direct
      // Placement is fixed by the index: the only way is always the victim.
      logic unused_repl;
      assign unused_repl = ^{clk, rst_n, idx, set_valid, touch_en, touch_idx, touch_way};
      assign victim_way  = '0;
   end else begin : g_lru2
      // Bit per set names the way to evict next.
      logic [SETS-1:0] lru_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lru_q <= '0;
         end else if (touch_en) begin
            lru_q[touch_idx] <= ~touch_way[0];
         end
      end

      always_comb begin
         if (!set_valid[0]) begin
            victim_way = WAY_W'(0);
         end else if (!set_valid[1]) begin
            victim_way = WAY_W'(1);
         end else begin
            victim_way = WAY_W'(lru_q[idx]);
         end
      end

      // R6: the touched way is never the next victim of its set.
      a_r6_lru_flip: assert property (@(posedge clk) disable iff (!rst_n)
         touch_en |=> (lru_q[$past(touch_idx)] != $past(touch_way[0])));
   end

endmodule

// File: rtl/assoc_lru_cache.sv
`timescale 1ns/1ps
module assoc_lru_cache
   import alc_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFF_W  = 2,
   parameter int unsigned SET_W  = 2,
   parameter int unsigned WAYS   = 2,
   parameter int unsigned CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    req_ready,
   output logic                    rsp_valid,
   output logic                    rsp_hit,
   output logic [DATA_W-1:0]       rsp_data,
   output logic                    mem_req_valid,
   output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [DATA_W-1:0]       mem_rsp_data,
   output logic [CNT_W-1:0]        hit_count,
   output logic [CNT_W-1:0]        miss_count
);
   localparam int unsigned WORD_W = ADDR_W - OFF_W;
   localparam int unsigned TAG_W  = WORD_W - SET_W;
   localparam int unsigned WAY_W  = way_idx_w(WAYS);

   // Elaboration-time parameter checks.
   if (WAYS < 1 || WAYS > 2) begin : g_chk_ways
      $error("assoc_lru_cache: WAYS must be 1 or 2");
   end
   if (OFF_W < 1) begin : g_chk_off
      $error("assoc_lru_cache: OFF_W must be at least 1");
   end
   if (SET_W < 1) begin : g_chk_set
      $error("assoc_lru_cache: SET_W must be at least 1");
   end
   if (ADDR_W <= OFF_W + SET_W) begin : g_chk_tag
      $error("assoc_lru_cache: address leaves no tag bits");
   end

   ctl_state_e              state_q;
   logic [WORD_W-1:0]       word_q;
   logic [WAY_W-1:0]        victim_q;
   logic [SET_W-1:0]        set_idx;
   logic [TAG_W-1:0]        look_tag;

   logic [WAYS-1:0]             way_valid;
   logic [WAYS-1:0][TAG_W-1:0]  way_tag;
   logic [WAYS-1:0][DATA_W-1:0] way_data;
   logic [WAYS-1:0]             way_wr;
   logic [WAYS-1:0]             hit_vec;
   logic                        hit;
   logic [WAY_W-1:0]            hit_way;
   logic [DATA_W-1:0]           hit_data;
   logic [WAY_W-1:0]            victim_way;

   logic                        fill_now;
   logic                        hit_now;
   logic                        miss_now;
   logic                        touch_en;
   logic [WAY_W-1:0]            touch_way;

   // The byte offset selects nothing inside a one-word block.
   logic unused_off;
   assign unused_off = ^req_addr[OFF_W-1:0];

   assign set_idx  = word_q[SET_W-1:0];
   assign look_tag = word_q[WORD_W-1:SET_W];

   assign req_ready = (state_q == CS_IDLE);
   assign hit_now   = (state_q == CS_LOOKUP) && hit;
   assign miss_now  = (state_q == CS_LOOKUP) && !hit;
   assign fill_now  = (state_q == CS_REFILL) && mem_rsp_valid;
   assign touch_en  = hit_now || fill_now;
   assign touch_way = hit_now ? hit_way : victim_q;

   // Way storage, one instance per way.
   genvar gw;
   for (gw = 0; gw < WAYS; gw++) begin : g_way
      assign way_wr[gw] = fill_now && (victim_q == WAY_W'(gw));

      alc_way_store #(
         .SET_W  (SET_W),
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W)
      ) store_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (set_idx),
         .rd_valid (way_valid[gw]),
         .rd_tag   (way_tag[gw]),
         .rd_data  (way_data[gw]),
         .wr_en    (way_wr[gw]),
         .wr_idx   (set_idx),
         .wr_tag   (look_tag),
         .wr_data  (mem_rsp_data)
      );
   end

   alc_tag_match #(
      .WAYS   (WAYS),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W),
      .WAY_W  (WAY_W)
   ) match_i (
      .way_valid (way_valid),
      .way_tag   (way_tag),
      .way_data  (way_data),
      .look_tag  (look_tag),
      .hit_vec   (hit_vec),
      .hit       (hit),
      .hit_way   (hit_way),
      .hit_data  (hit_data)
   );

   alc_replace #(
      .WAYS  (WAYS),
      .SET_W (SET_W),
      .WAY_W (WAY_W)
   ) repl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (set_idx),
      .set_valid  (way_valid),
      .touch_en   (touch_en),
      .touch_idx  (set_idx),
      .touch_way  (touch_way),
      .victim_way (victim_way)
   );

   // Controller: accept, look up, then either answer or refill.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= CS_IDLE;
         word_q        <= '0;
         victim_q      <= '0;
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_data      <= '0;
         mem_req_valid <= 1'b0;
         mem_req_addr  <= '0;
         hit_count     <= '0;
         miss_count    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            CS_IDLE: begin
               if (req_valid) begin
                  word_q  <= req_addr[ADDR_W-1:OFF_W];
                  state_q <= CS_LOOKUP;
               end
            end
            CS_LOOKUP: begin
               if (hit) begin
                  rsp_valid <= 1'b1;
                  rsp_hit   <= 1'b1;
                  rsp_data  <= hit_data;
                  hit_count <= hit_count + 1'b1;
                  state_q   <= CS_IDLE;
               end else begin
                  victim_q      <= victim_way;
                  mem_req_valid <= 1'b1;
                  mem_req_addr  <= word_q;
                  miss_count    <= miss_count + 1'b1;
                  state_q       <= CS_REFILL;
               end
            end
            CS_REFILL: begin
               if (mem_rsp_valid) begin
                  mem_req_valid <= 1'b0;
                  rsp_valid     <= 1'b1;
                  rsp_hit       <= 1'b0;
                  rsp_data      <= mem_rsp_data;
                  state_q       <= CS_IDLE;
               end
            end
            default: state_q <= CS_IDLE;
         endcase
      end
   end

   // R3: tags in a set are unique, so at most one way can match.
   a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CS_LOOKUP) |-> $onehot0(hit_vec));

   // R4: the refill request holds with a stable address until answered.
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R5: a valid way is never overwritten while its set still has an empty way.
   a_r5_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
      fill_now |-> !(way_valid[victim_q] && !(&way_valid)));

   // R9: the hit counter moves only together with a hit response.
   a_r9_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_count != $past(hit_count)) |-> (rsp_valid && rsp_hit));

   // R9: the miss counter moves only when a refill request starts.
   a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_count != $past(miss_count)) |-> (mem_req_valid && !$past(mem_req_valid)));

   // R10: each response is a single-cycle pulse.
   a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: tb/assoc_lru_cache_tb_top.sv
`timescale 1ns/1ps
module assoc_lru_cache_tb_top;
   localparam int MEM_LAT = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        req_valid;
   logic [6:0]  req_addr;
   logic        req_ready, req_ready_dm;
   logic        rsp_valid, rsp_valid_dm;
   logic        rsp_hit, rsp_hit_dm;
   logic [31:0] rsp_data, rsp_data_dm;
   logic        mem_req_valid, mem_req_valid_dm;
   logic [4:0]  mem_req_addr, mem_req_addr_dm;
   logic        mem_rsp_valid, mem_rsp_valid_dm;
   logic [31:0] mem_rsp_data, mem_rsp_data_dm;
   logic [15:0] hit_count, miss_count, hit_count_dm, miss_count_dm;

   int n_tests = 0;
   int n_fail  = 0;

   assoc_lru_cache dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .hit_count(hit_count), .miss_count(miss_count));

   assoc_lru_cache #(.SET_W(3), .WAYS(1)) dut_dm_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready_dm), .rsp_valid(rsp_valid_dm), .rsp_hit(rsp_hit_dm),
      .rsp_data(rsp_data_dm), .mem_req_valid(mem_req_valid_dm), .mem_req_addr(mem_req_addr_dm),
      .mem_rsp_valid(mem_rsp_valid_dm), .mem_rsp_data(mem_rsp_data_dm),
      .hit_count(hit_count_dm), .miss_count(miss_count_dm));

   function automatic logic [31:0] mem_word(input logic [4:0] w);
      return {8'h5A, 3'b000, w, 8'(w) * 8'd13 + 8'd7, 8'(~w)};
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // Word memory with fixed latency for both caches.
   int lat_a = 0;
   int lat_d = 0;
   initial begin
      mem_rsp_valid = 0; mem_rsp_data = '0;
      mem_rsp_valid_dm = 0; mem_rsp_data_dm = '0;
      forever begin
         @(negedge clk);
         if (mem_rsp_valid) mem_rsp_valid = 0;
         else if (mem_req_valid) begin
            if (lat_a >= MEM_LAT) begin
               mem_rsp_valid = 1; mem_rsp_data = mem_word(mem_req_addr); lat_a = 0;
            end else lat_a++;
         end
         if (mem_rsp_valid_dm) mem_rsp_valid_dm = 0;
         else if (mem_req_valid_dm) begin
            if (lat_d >= MEM_LAT) begin
               mem_rsp_valid_dm = 1; mem_rsp_data_dm = mem_word(mem_req_addr_dm); lat_d = 0;
            end else lat_d++;
         end
      end
   end

   // Reference model of both organisations.
   logic [2:0] rtag [4][2];
   bit         rval [4][2];
   bit         rlru [4];
   logic [1:0] dtag [8];
   bit         dval [8];
   int exp_hits = 0, exp_miss = 0, exp_dm_hits = 0, exp_dm_miss = 0;

   task automatic ref_step(input logic [6:0] a, output bit h2, output bit hd);
      int s = int'(a[3:2]);
      int sd = int'(a[4:2]);
      int v;
      h2 = 0;
      for (int w = 0; w < 2; w++) begin
         if (rval[s][w] && rtag[s][w] == a[6:4]) begin
            h2 = 1; rlru[s] = (w == 0);
         end
      end
      if (!h2) begin
         if (!rval[s][0]) v = 0;
         else if (!rval[s][1]) v = 1;
         else v = int'(rlru[s]);
         rval[s][v] = 1; rtag[s][v] = a[6:4]; rlru[s] = (v == 0);
         exp_miss++;
      end else exp_hits++;
      hd = dval[sd] && (dtag[sd] == a[6:5]);
      if (!hd) begin
         dval[sd] = 1; dtag[sd] = a[6:5]; exp_dm_miss++;
      end else exp_dm_hits++;
   endtask

   task automatic access(input logic [6:0] a, input bit inject, output bit h2, output bit hd);
      bit eh, ed, got2, gotd, saw_mem;
      int waits;
      ref_step(a, eh, ed);
      while (!(req_ready && req_ready_dm)) @(negedge clk);
      req_valid = 1; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      got2 = 0; gotd = 0; saw_mem = 0; waits = 0; h2 = 0; hd = 0;
      while (!(got2 && gotd)) begin
         if (!got2 && rsp_valid) begin
            got2 = 1; h2 = rsp_hit;
            chk("R5/R6 hit vs reference", rsp_hit, eh);
            chk("R3/R4 returned word", rsp_data, mem_word(a[6:2]));
            chk("R10 ready after response", req_ready, 1);
            if (eh) chk("R3 hit latency", waits, 1);
         end
         if (!gotd && rsp_valid_dm) begin
            gotd = 1; hd = rsp_hit_dm;
            chk("R8 direct-mapped hit vs reference", rsp_hit_dm, ed);
            chk("R8 direct-mapped word", rsp_data_dm, mem_word(a[6:2]));
         end
         if (mem_req_valid && !saw_mem) begin
            saw_mem = 1;
            chk("R4 refill word address", mem_req_addr, a[6:2]);
         end
         if (inject && !req_ready && !req_ready_dm && !req_valid) begin
            req_valid = 1; req_addr = ~a;
         end else req_valid = 0;
         if (!(got2 && gotd)) begin
            @(negedge clk); waits++;
         end
      end
      req_valid = 0;
      chk("R3/R4 memory used only on miss", saw_mem, !eh);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      bit h2, hd;
      int trace_w [6] = '{0, 8, 0, 6, 8, 16};
      bit trace_h [6] = '{0, 0, 1, 0, 1, 0};
      int set1_w  [7] = '{1, 5, 1, 9, 5, 9, 1};
      bit set1_h  [7] = '{0, 0, 1, 0, 0, 1, 0};
      logic [15:0] lfsr = 16'hACE1;
      for (int s = 0; s < 4; s++) begin
         rlru[s] = 0;
         for (int w = 0; w < 2; w++) begin rval[s][w] = 0; rtag[s][w] = '0; end
      end
      for (int s = 0; s < 8; s++) begin dval[s] = 0; dtag[s] = '0; end
      req_valid = 0; req_addr = '0; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 req_ready after reset", req_ready, 1);
      chk("R1 rsp_valid after reset", rsp_valid, 0);
      chk("R1 mem_req_valid after reset", mem_req_valid, 0);
      chk("R1 hit_count after reset", hit_count, 0);
      chk("R1 miss_count after reset", miss_count, 0);

      // R7 / R8: the six-access trace.
      for (int i = 0; i < 6; i++) begin
         access(7'(trace_w[i] * 4), 0, h2, hd);
         chk("R7 trace result", h2, trace_h[i]);
         chk("R8 direct-mapped trace result", hd, 0);
      end
      chk("R9 hits after trace", hit_count, 2);
      chk("R9 misses after trace", miss_count, 4);
      chk("R9 direct-mapped misses after trace", miss_count_dm, 6);

      // R2: offset bits do not select anything.
      access(7'd35, 0, h2, hd);
      chk("R2 offset 3 hits word 8", h2, 1);
      access(7'd66, 0, h2, hd);
      chk("R2 offset 2 hits word 16", h2, 1);

      // R5 / R6: three tags contending for set 1.
      for (int i = 0; i < 7; i++) begin
         access(7'(set1_w[i] * 4), 0, h2, hd);
         chk("R5/R6 set 1 pattern", h2, set1_h[i]);
      end

      // R10: requests offered while busy are ignored.
      for (int i = 0; i < 4; i++) begin
         access(7'(((i * 4 + 3) * 4) % 128), 1, h2, hd);
      end
      chk("R10 hit_count ignores busy requests", hit_count, exp_hits);
      chk("R10 miss_count ignores busy requests", miss_count, exp_miss);

      // Pseudo-random sweep over full byte addresses.
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         access(lfsr[6:0], (i % 5) == 0, h2, hd);
      end
      chk("R9 final hit_count", hit_count, exp_hits);
      chk("R9 final miss_count", miss_count, exp_miss);
      chk("R9 final direct-mapped hit_count", hit_count_dm, exp_dm_hits);
      chk("R9 final direct-mapped miss_count", miss_count_dm, exp_dm_miss);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule